// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Captured Condition Flags

This block combines a purely combinational arithmetic-logic unit with a small clocked register that holds its condition flags. Two operands, a 4-bit operation selector and a carry input feed the combinational path. The result appears on the output in the same cycle, with no register in between.

Carry, overflow, negative and zero are worked out from that result and stored on a rising clock edge, but only when the flag write enable is high. A controller can therefore choose which operations leave their condition behind for a later conditional step.

Operation codes: 0 passes A, 1 passes B, 2 and 3 both add, 4 adds with carry-in, and 5 subtracts. Codes 6 to 9 are bitwise AND, OR, XOR and NOT A. Code 10 shifts left and code 11 shifts right. Codes 12 to 15 pass A.

Top module: `alu_flags_unit`

## Requirements
- R1: With code 0 the result equals A, and the stored carry and overflow are 0.
- R2: With code 1 the result equals B, and the stored carry and overflow are 0.
- R3: Codes 2 and 3 both give the low 8 bits of A+B, and the stored carry is the ninth bit of that sum.
- R4: Code 4 gives the low 8 bits of A+B+carry_in, and the stored carry is the ninth bit of that sum.
- R5: Code 5 gives the low 8 bits of A-B. The stored carry is 1 exactly when A >= B as unsigned values, so carry 1 means no borrow.
- R6: For codes 2 to 5, the stored overflow is 1 exactly when the true two's-complement sum or difference lies outside -128..127. For every other code it is 0.
- R7: The stored negative flag equals bit 7 of the result. The stored zero flag is 1 exactly when all 8 result bits are 0.
- R8: Codes 6, 7, 8 and 9 give A AND B, A OR B, A XOR B and NOT A respectively, with stored carry and overflow both 0.
- R9: Code 10 gives A shifted left by one with a 0 filled in at bit 0, and the stored carry is the old bit 7. Code 11 gives A shifted right by one with a 0 filled in at bit 7, and the stored carry is the old bit 0.
- R10: Codes 12 to 15 pass A, with stored carry and overflow both 0.
- R11: The flags take new values only on a rising clock edge while flag_we is 1. While flag_we is 0 they keep their values, whatever the other inputs do.
- R12: A synchronous active-high reset clears all four flags to 0 and takes priority over flag_we.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flags register |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| func | input | 4 | Operation selector |
| carry_in | input | 1 | Carry input used by code 4 |
| flag_we | input | 1 | Flag write enable |
| result | output | 8 | Combinational result |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |

## Verification
The assertions check on every cycle the properties that involve only the ports and the flags register. These are the reset clearing, the flags holding while the enable is low, the zero and negative flags following the result of the previous cycle, the pass-through result, and carry and overflow staying clear for pass and bitwise codes. The exact arithmetic cannot be stated as a cycle property without copying the datapath. That covers the sums, the borrow convention, the signed overflow boundaries and the bits shifted out. Only the bench sweep shows it, by comparing every code over all values of A against an integer model.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    localparam int FUNC_W = 4;

    localparam logic [FUNC_W-1:0] OP_PASS_A  = 4'd0;
    localparam logic [FUNC_W-1:0] OP_PASS_B  = 4'd1;
    localparam logic [FUNC_W-1:0] OP_ADD     = 4'd2;
    localparam logic [FUNC_W-1:0] OP_ADD_ALT = 4'd3;
    localparam logic [FUNC_W-1:0] OP_ADC     = 4'd4;
    localparam logic [FUNC_W-1:0] OP_SUB     = 4'd5;
    localparam logic [FUNC_W-1:0] OP_AND     = 4'd6;
    localparam logic [FUNC_W-1:0] OP_OR      = 4'd7;
    localparam logic [FUNC_W-1:0] OP_XOR     = 4'd8;
    localparam logic [FUNC_W-1:0] OP_NOT     = 4'd9;
    localparam logic [FUNC_W-1:0] OP_SHL     = 4'd10;
    localparam logic [FUNC_W-1:0] OP_SHR     = 4'd11;

    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
    } flags_t;

    // Signed overflow of an addition: the operand signs agree and the sum sign does not.
    function automatic logic add_overflow(input logic sign_a, input logic sign_b,
                                          input logic sign_sum);
        return (sign_a == sign_b) && (sign_sum != sign_a);
    endfunction

endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_flags_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic [FUNC_W-1:0] func,
    input  logic              cin,
    output logic [W-1:0]      res,
    output logic              c_out,
    output logic              v_out
);

    logic [W-1:0] b_eff;
    logic         c_eff;
    logic         arith;
    logic [W:0]   sum;

    always_comb begin
        b_eff = '0;
        c_eff = 1'b0;
        arith = 1'b0;
        res   = a;
        c_out = 1'b0;
        v_out = 1'b0;
        case (func)
            OP_PASS_A: res = a;
            OP_PASS_B: res = b;
            OP_ADD, OP_ADD_ALT: begin
                arith = 1'b1;
                b_eff = b;
            end
            OP_ADC: begin
                arith = 1'b1;
                b_eff = b;
                c_eff = cin;
            end
            OP_SUB: begin
                arith = 1'b1;
                b_eff = ~b;
                c_eff = 1'b1;
            end
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_NOT: res = ~a;
            OP_SHL: begin
                res   = {a[W-2:0], 1'b0};
                c_out = a[W-1];
            end
            OP_SHR: begin
                res   = {1'b0, a[W-1:1]};
                c_out = a[0];
            end
            default: res = a;
        endcase
        sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        if (arith) begin
            res   = sum[W-1:0];
            c_out = sum[W];
            v_out = add_overflow(a[W-1], b_eff[W-1], sum[W-1]);
        end
    end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_flags_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] res,
    input  logic         c_in,
    input  logic         v_in,
    output flags_t       q
);

    flags_t d;

    always_comb begin
        d.c = c_in;
        d.v = v_in;
        d.n = res[W-1];
        d.z = (res == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= d;
    end

    assert_reset_clear_R12: assert property (@(posedge clk)
        rst |=> (q == '0));

    assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_flags_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [FUNC_W-1:0] func,
    input  logic              carry_in,
    input  logic              flag_we,
    output logic [W-1:0]      result,
    output logic              flag_c,
    output logic              flag_v,
    output logic              flag_n,
    output logic              flag_z
);

    logic   c_raw;
    logic   v_raw;
    flags_t flags_q;

    alu_core #(.W(W)) u_core (
        .a     (op_a),
        .b     (op_b),
        .func  (func),
        .cin   (carry_in),
        .res   (result),
        .c_out (c_raw),
        .v_out (v_raw)
    );

    alu_flag_reg #(.W(W)) u_flags (
        .clk  (clk),
        .rst  (rst),
        .we   (flag_we),
        .res  (result),
        .c_in (c_raw),
        .v_in (v_raw),
        .q    (flags_q)
    );

    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;
    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;

    assert_pass_a_result_R1: assert property (@(posedge clk) disable iff (rst)
        (func == OP_PASS_A) |-> (result == op_a));

    assert_pass_clears_cv_R2: assert property (@(posedge clk) disable iff (rst)
        (flag_we && (func == OP_PASS_A || func == OP_PASS_B)) |=> (!flag_c && !flag_v));

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flag_z == ($past(result) == '0)));

    assert_neg_flag_R7: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flag_n == $past(result[W-1])));

    assert_bitwise_clears_cv_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_we && func >= OP_AND && func <= OP_NOT) |=> (!flag_c && !flag_v));

    assert_upper_codes_clear_cv_R10: assert property (@(posedge clk) disable iff (rst)
        (flag_we && func >= 4'd12) |=> (!flag_c && !flag_v));

endmodule

// File: tb/tb_alu_flags_unit.sv
`timescale 1ns/1ps
module tb_alu_flags_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic [3:0] func = '0;
    logic       carry_in = 1'b0;
    logic       flag_we = 1'b0;
    logic [7:0] result;
    logic       flag_c, flag_v, flag_n, flag_z;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    alu_flags_unit dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .func(func),
        .carry_in(carry_in), .flag_we(flag_we), .result(result),
        .flag_c(flag_c), .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (func=%0d a=%h b=%h cin=%b)",
                     req, act, exp, func, op_a, op_b, carry_in);
        end
    endtask

    // Returns {carry, overflow, result[7:0]} from integer arithmetic.
    function automatic logic [9:0] model(input int f, input int a, input int b, input int ci);
        int r, c, v, sa, sb, s;
        r = a; c = 0; v = 0;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        case (f)
            1: r = b;
            2, 3: begin r = a + b; c = (r > 255); s = sa + sb; v = (s > 127 || s < -128); end
            4: begin r = a + b + ci; c = (r > 255); s = sa + sb + ci; v = (s > 127 || s < -128); end
            5: begin r = a - b + 256; c = (a >= b); s = sa - sb; v = (s > 127 || s < -128); end
            6: r = a & b;
            7: r = a | b;
            8: r = a ^ b;
            9: r = 255 - a;
            10: begin r = a * 2; c = (a >= 128); end
            11: begin r = a / 2; c = a % 2; end
            default: r = a;
        endcase
        r = r % 256;
        return {c[0], v[0], r[7:0]};
    endfunction

    function automatic string req_of(input int f);
        case (f)
            0: return "R1";
            1: return "R2";
            2, 3: return "R3";
            4: return "R4";
            5: return "R5";
            6, 7, 8, 9: return "R8";
            10, 11: return "R9";
            default: return "R10";
        endcase
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [9:0] e;
        string rq;
        // R12: reset state
        @(posedge clk); @(posedge clk);
        #1;
        check("R12 reset flags", {flag_c, flag_v, flag_n, flag_z}, 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        flag_we = 1'b1;

        for (int f = 0; f < 16; f++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b += 51) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        op_a = a[7:0]; op_b = b[7:0]; func = f[3:0]; carry_in = ci[0];
                        e = model(f, a, b, ci);
                        rq = req_of(f);
                        #1;
                        check({rq, " result"}, result, e[7:0]);
                        @(posedge clk);
                        #1;
                        check({rq, " carry"}, flag_c, e[9]);
                        check({rq, "/R6 overflow"}, flag_v, e[8]);
                        check("R7 negative", flag_n, e[7]);
                        check("R7 zero", flag_z, (e[7:0] == 8'h00));
                        @(negedge clk);
                    end
                end
            end
        end

        // R6 boundaries: 0x7F+0x01 overflows, 0x80-0x01 overflows, 0x7F-0xFF overflows
        op_a = 8'h7F; op_b = 8'h01; func = 4'd2; carry_in = 1'b0;
        @(posedge clk); #1;
        check("R6 add boundary", {flag_c, flag_v, flag_n, flag_z}, 4'b0110);
        @(negedge clk);
        op_a = 8'h80; op_b = 8'h01; func = 4'd5;
        @(posedge clk); #1;
        check("R6 sub boundary", {flag_c, flag_v, flag_n, flag_z}, 4'b1100);
        @(negedge clk);
        // R5: equal operands, no borrow, zero
        op_a = 8'h33; op_b = 8'h33; func = 4'd5;
        @(posedge clk); #1;
        check("R5 equal sub", {flag_c, flag_v, flag_n, flag_z}, 4'b1001);
        @(negedge clk);
        // R4: 0xFF+0x00+1 wraps to zero with carry
        op_a = 8'hFF; op_b = 8'h00; func = 4'd4; carry_in = 1'b1;
        #1;
        check("R4 carry wrap result", result, 8'h00);
        @(posedge clk); #1;
        check("R4 carry wrap flags", {flag_c, flag_v, flag_n, flag_z}, 4'b1001);
        @(negedge clk);

        // R11: load a known set, then drive a different operation with enable low
        op_a = 8'h7F; op_b = 8'h01; func = 4'd2; carry_in = 1'b0;
        @(posedge clk); #1;
        check("R11 preload", {flag_c, flag_v, flag_n, flag_z}, 4'b0110);
        @(negedge clk);
        flag_we = 1'b0;
        op_a = 8'hFF; op_b = 8'h01; func = 4'd2;
        @(posedge clk); @(posedge clk); #1;
        check("R11 hold while disabled", {flag_c, flag_v, flag_n, flag_z}, 4'b0110);
        @(negedge clk);
        flag_we = 1'b1;
        @(posedge clk); #1;
        check("R11 update when enabled", {flag_c, flag_v, flag_n, flag_z}, 4'b1001);
        @(negedge clk);

        // R12: reset wins over enable
        op_a = 8'h80; op_b = 8'h00; func = 4'd0;
        rst = 1'b1;
        @(posedge clk); #1;
        check("R12 reset over enable", {flag_c, flag_v, flag_n, flag_z}, 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R7 after reset", {flag_c, flag_v, flag_n, flag_z}, 4'b0010);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule